// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block sits in the system clock domain and turns one conversion request into a single 16-bit write to a three-wire serial DAC. The host offers a 10-bit code and a 2-bit operating mode over a valid/ready handshake. The sequencer builds the frame and shifts it out MSB first on a data line. A framing strobe stays low for the whole word. The serial clock idles low and the data line changes on its rising edge, so every bit is settled when the receiver samples on the falling edge.

The serial clock half-period is set as a count of system cycles. The word can go out as one burst of 16 clocks, or as two bytes with a programmable pause between them. The framing strobe stays low through that pause. After each word the strobe is held high for a programmable number of cycles, which meets the receiver's minimum high time. The strobe then drops and parks low with the data and clock lines, because the receiver draws less current when its inputs are low. That falling edge also arms the receiver for the next word. After a reset no such edge has occurred yet, so the first word is preceded by one high pulse of the same length.

Top module: `dac_wr_seq`

## Requirements
- R1: A word is 16 bits sent MSB first. Bits 15:14 are 0, bits 13:12 carry `mode_i`, bits 11:2 carry `code_i`, and bits 1:0 are 0.
- R2: `ser_clk_o` idles low. `ser_dat_o` changes only on a rising edge of `ser_clk_o` or outside a word, so it is stable across every falling edge.
- R3: With H = `div_i`, or 1 when `div_i` is 0, every high phase and every low phase of `ser_clk_o` inside a word lasts H system cycles.
- R4: `frame_o` stays low through all 16 falling edges. It rises H cycles after the 16th falling edge and never rises after 1 to 15 falling edges.
- R5: When `split_i` is 1, the low phase between the 8th and 9th falling edges lasts H + `mid_i` cycles and `frame_o` stays low. With `mid_i` = 0, or with `split_i` = 0, the word is one continuous burst.
- R6: After each word, `frame_o` is high for exactly G cycles, where G = `gap_i`, or 1 when `gap_i` is 0. No `ser_clk_o` edge occurs while `frame_o` is high.
- R7: The first word after reset is preceded by a `frame_o` high pulse of G cycles, and the serial clock starts H cycles after that pulse ends.
- R8: `req_ready_o` falls on acceptance and returns high exactly (first ? G : 0) + 33·H + (split ? `mid_i` : 0) + G cycles later.
- R9: The code, mode and all timing inputs are captured at acceptance. Changing them while a word is in flight has no effect on that word.
- R10: In reset and whenever idle, `req_ready_o` is 1 and `frame_o`, `ser_clk_o` and `ser_dat_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| split_i | input | 1 | 1 = send the word as two 8-clock bursts |
| div_i | input | 8 | Serial clock half-period in cycles (0 acts as 1) |
| mid_i | input | 8 | Extra low cycles between the two bursts |
| gap_i | input | 8 | Framing strobe high time in cycles (0 acts as 1) |
| req_valid_i | input | 1 | Request valid |
| code_i | input | 10 | DAC code |
| mode_i | input | 2 | Operating mode field |
| req_ready_o | output | 1 | Ready to accept a request |
| frame_o | output | 1 | Framing strobe, low during a word |
| ser_clk_o | output | 1 | Serial clock |
| ser_dat_o | output | 1 | Serial data |

## Verification
The assertions assume the timing inputs are read only at acceptance. They rely on the zero clamp, so no phase timer is ever loaded with a zero length. They also assume reset is the only way a word can end early. The stimulus offers a request only while ready is high and drops valid on the next cycle. It covers zero divider and zero gap values to exercise the clamp. It changes every input in mid-word to show that the captured copies are the ones used. It applies reset only between clock edges, and the bench then expects the full pre-word pulse again.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;
  localparam int FRAME_W = 16;
  localparam int HDR_W   = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,   // strobe high before the first word after reset
    ST_LEAD,  // strobe low, clock low, before first rise
    ST_HIGH,
    ST_LOW,
    ST_MID,   // pause between bytes
    ST_GAP    // strobe high after a word
  } seq_st_e;
endpackage

// File: rtl/dac_wr_timer.sv
module dac_wr_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= len_i;
    else if (cnt_q > W'(1))     cnt_q <= cnt_q - W'(1);
  end

  // expires in the last cycle of a phase of len_i cycles
  assign expire_o = (cnt_q == W'(1));

  p_len_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (len_i != '0));
endmodule

// File: rtl/dac_wr_shreg.sv
module dac_wr_shreg #(
  parameter int FW    = 16,
  localparam int CW   = $clog2(FW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [FW-1:0] frame_i,
  input  logic          shift_i,
  input  logic          fall_i,
  input  logic          clr_i,
  output logic          dat_o,
  output logic [CW-1:0] sent_o
);
  logic [FW-1:0] sh_q;
  logic          dat_q;
  logic [CW-1:0] sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      dat_q  <= 1'b0;
      sent_q <= '0;
    end else begin
      if (load_i) begin
        sh_q   <= frame_i;
        dat_q  <= 1'b0;
        sent_q <= '0;
      end else begin
        if (shift_i) begin
          dat_q <= sh_q[FW-1];
          sh_q  <= {sh_q[FW-2:0], 1'b0};
        end else if (clr_i) begin
          dat_q <= 1'b0;
        end
        if (fall_i) sent_q <= sent_q + 1'b1;
      end
    end
  end

  assign dat_o  = dat_q;
  assign sent_o = sent_q;

  p_sent_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sent_q <= CW'(FW));
endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dac_wr_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int MODE_W = 2,
  parameter int DIV_W  = 8,
  parameter int MID_W  = 8,
  parameter int GAP_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              split_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [MID_W-1:0]  mid_i,
  input  logic [GAP_W-1:0]  gap_i,
  input  logic              req_valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              req_ready_o,
  output logic              frame_o,
  output logic              ser_clk_o,
  output logic              ser_dat_o
);
  localparam int TAIL_W = FRAME_W - HDR_W - MODE_W - CODE_W;
  localparam int TW = (DIV_W > MID_W) ? ((DIV_W > GAP_W) ? DIV_W : GAP_W)
                                      : ((MID_W > GAP_W) ? MID_W : GAP_W);
  localparam int CW = $clog2(FRAME_W + 1);

  seq_st_e st_q, st_d;
  logic [TW-1:0] h_q, m_q, g_q, h_in, g_in, len;
  logic          split_q, armed_q;
  logic          ld_t, exp_t, ld_f, shift, fall, clr;
  logic [FRAME_W-1:0] frame_in;
  logic [CW-1:0] sent;

  assign h_in     = (div_i == '0) ? TW'(1) : TW'(div_i);
  assign g_in     = (gap_i == '0) ? TW'(1) : TW'(gap_i);
  assign frame_in = FRAME_W'({mode_i, code_i}) << TAIL_W;

  always_comb begin
    st_d  = st_q;
    ld_t  = 1'b0;
    len   = '0;
    ld_f  = 1'b0;
    shift = 1'b0;
    fall  = 1'b0;
    clr   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        ld_f = 1'b1;
        ld_t = 1'b1;
        if (armed_q) begin st_d = ST_LEAD; len = h_in; end
        else         begin st_d = ST_PRE;  len = g_in; end
      end
      ST_PRE: if (exp_t) begin
        st_d = ST_LEAD; ld_t = 1'b1; len = h_q;
      end
      ST_LEAD, ST_MID: if (exp_t) begin
        st_d = ST_HIGH; ld_t = 1'b1; len = h_q; shift = 1'b1;
      end
      ST_HIGH: if (exp_t) begin
        st_d = ST_LOW; ld_t = 1'b1; len = h_q; fall = 1'b1;
      end
      ST_LOW: if (exp_t) begin
        ld_t = 1'b1;
        if (sent == CW'(FRAME_W)) begin
          st_d = ST_GAP; len = g_q; clr = 1'b1;
        end else if (split_q && sent == CW'(FRAME_W / 2) && m_q != '0) begin
          st_d = ST_MID; len = m_q;
        end else begin
          st_d = ST_HIGH; len = h_q; shift = 1'b1;
        end
      end
      ST_GAP: if (exp_t) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      h_q     <= TW'(1);
      m_q     <= '0;
      g_q     <= TW'(1);
      split_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ld_f) begin
        h_q     <= h_in;
        m_q     <= TW'(mid_i);
        g_q     <= g_in;
        split_q <= split_i;
      end
      if (st_q == ST_GAP && exp_t) armed_q <= 1'b1;
    end
  end

  dac_wr_timer #(.W(TW)) u_timer (
    .clk_i, .rst_ni, .load_i(ld_t), .len_i(len), .expire_o(exp_t)
  );

  dac_wr_shreg #(.FW(FRAME_W)) u_shreg (
    .clk_i, .rst_ni, .load_i(ld_f), .frame_i(frame_in), .shift_i(shift),
    .fall_i(fall), .clr_i(clr), .dat_o(ser_dat_o), .sent_o(sent)
  );

  assign req_ready_o = (st_q == ST_IDLE);
  assign frame_o     = (st_q == ST_PRE) || (st_q == ST_GAP);
  assign ser_clk_o   = (st_q == ST_HIGH);

  p_dat_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ser_clk_o) |-> $stable(ser_dat_o));
  p_rise_after_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_o) |-> (sent == '0 || sent == CW'(FRAME_W)));
  p_no_clk_in_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> !ser_clk_o);
  p_busy_after_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  p_idle_parked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!frame_o && !ser_clk_o && !ser_dat_o));
endmodule

// File: tb/dac_wr_seq_test.sv
module dac_wr_seq_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [9:0] code;
    logic [1:0] mode;
    logic [7:0] div;
    logic       split;
    logic [7:0] mid;
    logic [7:0] gap;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{10'h3FF, 2'd0, 8'd1, 1'b0, 8'd0, 8'd3},
    '{10'h000, 2'd3, 8'd2, 1'b0, 8'd0, 8'd5},
    '{10'h2AA, 2'd1, 8'd3, 1'b1, 8'd4, 8'd2},
    '{10'h155, 2'd2, 8'd0, 1'b1, 8'd0, 8'd0},
    '{10'h201, 2'd1, 8'd4, 1'b1, 8'd9, 8'd7},
    '{10'h1FF, 2'd2, 8'd2, 1'b0, 8'd6, 8'd4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic split = 1'b0, valid = 1'b0;
  logic [7:0] div = '0, mid = '0, gap = '0;
  logic [9:0] code = '0;
  logic [1:0] mode = '0;
  logic ready, frm, sclk, sdat;

  int n_chk = 0, n_fail = 0;
  bit armed = 1'b0;

  // monitor state
  int x_h = 1, x_m = 0, x_g = 1;
  bit x_split = 1'b0;
  bit active = 1'b0, p_frm = 1'b0, p_sclk = 1'b0;
  int nf = 0, hi_run = 0, lo_run = 0, sh_run = 0;
  int frames = 0, e_hi = 0, e_lo = 0, e_tail = 0, e_gap = 0, e_nf = 0, e_clk = 0;
  logic [15:0] rx = '0, rx_last = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_wr_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .split_i(split), .div_i(div), .mid_i(mid),
    .gap_i(gap), .req_valid_i(valid), .code_i(code), .mode_i(mode),
    .req_ready_o(ready), .frame_o(frm), .ser_clk_o(sclk), .ser_dat_o(sdat)
  );

  // receiver model, sampled between edges
  always @(negedge clk) begin
    if (!rst_n) begin
      active = 1'b0; nf = 0; hi_run = 0; lo_run = 0; sh_run = 0;
      p_frm = 1'b0; p_sclk = 1'b0;
    end else begin
      if (frm && !p_frm) begin
        if (active) begin
          if (nf == 16) begin
            frames++; rx_last = rx;
            if (lo_run != x_h) e_tail++;
          end else if (nf != 0) e_nf++;
        end
        active = 1'b0; sh_run = 0;
      end
      if (!frm && p_frm) begin
        if (sh_run != x_g) e_gap++;
        active = 1'b1; nf = 0; rx = '0; lo_run = 0; hi_run = 0;
      end
      if (frm) begin
        sh_run++;
        if (sclk) e_clk++;
      end else if (active) begin
        if (sclk) begin
          if (!p_sclk) begin
            if (nf > 0 && lo_run != ((x_split && nf == 8) ? x_h + x_m : x_h)) e_lo++;
            hi_run = 0;
          end
          hi_run++;
        end else begin
          if (p_sclk) begin
            rx = {rx[14:0], sdat}; nf++;
            if (hi_run != x_h) e_hi++;
            lo_run = 0;
          end
          lo_run++;
        end
      end
      p_frm = frm; p_sclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(ready == 1'b1, req, "ready idle", int'(ready), 1);
    chk(frm == 1'b0,   req, "strobe idle", int'(frm), 0);
    chk(sclk == 1'b0,  req, "clock idle", int'(sclk), 0);
    chk(sdat == 1'b0,  req, "data idle", int'(sdat), 0);
  endtask

  task automatic send(input vec_t v, input bit scramble);
    int h, g, m, t_exp, busy;
    int s_fr, s_hi, s_lo, s_tail, s_gap, s_nf, s_clk;
    logic [15:0] f_exp;
    h = (v.div == 0) ? 1 : int'(v.div);
    g = (v.gap == 0) ? 1 : int'(v.gap);
    m = int'(v.mid);
    t_exp = (armed ? 0 : g) + 33 * h + (v.split ? m : 0) + g;
    f_exp = {2'b00, v.mode, v.code, 2'b00};
    while (!ready) @(negedge clk);
    x_h = h; x_g = g; x_m = m; x_split = v.split;
    s_fr = frames; s_hi = e_hi; s_lo = e_lo; s_tail = e_tail;
    s_gap = e_gap; s_nf = e_nf; s_clk = e_clk;
    code = v.code; mode = v.mode; div = v.div; split = v.split;
    mid = v.mid; gap = v.gap; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    busy = 0;
    while (!ready && busy < 100000) begin
      busy++;
      if (scramble && busy == 3) begin
        code = ~v.code; mode = ~v.mode; div = v.div + 8'd3;
        split = ~v.split; mid = v.mid + 8'd2; gap = v.gap + 8'd5;
      end
      @(negedge clk);
    end
    @(negedge clk);
    chk(rx_last == f_exp, scramble ? "R1/R9" : "R1", "word bits",
        int'(rx_last), int'(f_exp));
    chk(frames - s_fr == 1, "R4", "words completed", frames - s_fr, 1);
    chk(e_nf == s_nf, "R4", "early strobe rises", e_nf - s_nf, 0);
    chk(e_hi == s_hi, "R3", "high phase errors", e_hi - s_hi, 0);
    chk(e_lo == s_lo, v.split ? "R5" : "R3", "low phase errors", e_lo - s_lo, 0);
    chk(e_tail == s_tail, "R4", "tail low errors", e_tail - s_tail, 0);
    chk(e_gap == s_gap, armed ? "R6" : "R6/R7", "strobe high length errors",
        e_gap - s_gap, 0);
    chk(e_clk == s_clk, "R6", "clock while strobe high", e_clk - s_clk, 0);
    chk(busy == t_exp, armed ? "R8" : "R8/R7", "busy cycles", busy, t_exp);
    chk_idle("R10");
    armed = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R10");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle("R10");

    for (int i = 0; i < 6; i++) send(VECS[i], i == 4);

    // reset in the middle of a word
    code = 10'h0F0; mode = 2'd1; div = 8'd2; split = 1'b1; mid = 8'd3; gap = 8'd2;
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #(CLK_PERIOD/4);
    chk_idle("R10");
    @(negedge clk);
    rst_n = 1'b1;
    armed = 1'b0;
    @(negedge clk);
    chk_idle("R10");
    send(VECS[1], 1'b0);
    send(VECS[3], 1'b0);
    send(VECS[0], 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule